// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Event Detector

This block watches a group of general-purpose input lines and turns activity on them into interrupt status. Each line has its own settings. It can be level-sensed or edge-sensed, active-high/rising or active-low/falling, and it can also be set to respond to both edges. The surrounding register logic holds these settings and presents them as per-line vectors. Input pins are asynchronous, so they pass through a synchroniser before any detection.

The block keeps a raw status vector for every line, whether or not the line is enabled. A masked status vector is the raw status ANDed with the per-line enable. A single registered interrupt output combines all masked bits. An edge event stays latched until software pulses a 1 on that line's bit of the clear vector. A level event needs no clear: it follows the synchronised pin. If an edge and a clear for the same line land in the same cycle, the new edge wins and the status stays set.

Top module: `gpio_irq_detect`

## Requirements
- R1: Out of reset, rawStatus, maskedStatus and irqOut are all zero.
- R2: A line with senseLevel=1 and polarityHigh=1 shows rawStatus=1 while its pin is high and 0 while it is low. A pin change first appears in rawStatus on the third rising clock edge after the change.
- R3: A line with senseLevel=1 and polarityHigh=0 shows rawStatus=1 while its pin is low.
- R4: A line with senseLevel=0, bothEdges=0 and polarityHigh=1 sets its status on a 0-to-1 pin transition and not on a 1-to-0 transition.
- R5: A line with senseLevel=0, bothEdges=0 and polarityHigh=0 sets its status on a 1-to-0 transition and not on a 0-to-1 transition.
- R6: A line with senseLevel=0 and bothEdges=1 sets its status on any transition, whatever polarityHigh holds.
- R7: An edge-sensed status stays set until a cycle in which its clearPulse bit is 1. A 0 in that bit, or a 1 in another line's bit, leaves it unchanged.
- R8: clearPulse has no effect on a level-sensed line, whose status keeps following the pin.
- R9: maskedStatus equals rawStatus AND lineEnable. rawStatus is computed for disabled lines too.
- R10: irqOut is registered. It equals the OR of maskedStatus as it stood one clock earlier.
- R11: When an edge is detected on a line in the same cycle that its clearPulse bit is 1, the status remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| pinIn | input | LINES | Asynchronous input pins |
| senseLevel | input | LINES | 1 = level sensing, 0 = edge sensing |
| polarityHigh | input | LINES | 1 = high level / rising edge, 0 = low level / falling edge |
| bothEdges | input | LINES | 1 = any transition sets status (edge mode only) |
| lineEnable | input | LINES | Per-line interrupt enable |
| clearPulse | input | LINES | One-cycle write-one-to-clear for edge status |
| rawStatus | output | LINES | Unmasked per-line status |
| maskedStatus | output | LINES | rawStatus AND lineEnable |
| irqOut | output | 1 | Registered OR of masked status |

## Verification
A pin change reaches the second synchroniser flop on the second clock edge. Detection is combinational from there, so rawStatus updates on the third edge and irqOut on the fourth. maskedStatus follows an enable change in the same cycle, and irqOut follows one edge later. The bench drives every input just after a falling edge and samples on later falling edges. It waits at least the due number of edges, and in the latency and coincidence tests exactly that number. The same-cycle clear test holds clearPulse across the third edge after the pin toggles, the edge on which the detection strobe is live.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Per-line strobes from the detection control to the status datapath.
  typedef struct packed {
    logic isLevel;      // line is level-sensed
    logic levelActive;  // synchronised pin is at the active level
    logic edgeHit;      // qualifying transition seen this cycle
  } lineStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  pinIn,
  input  logic [LINES-1:0]  senseLevel,
  input  logic [LINES-1:0]  polarityHigh,
  input  logic [LINES-1:0]  bothEdges,
  output lineStrobe_t       strobes [LINES]
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][LINES-1:0] syncPipe;
  logic [LINES-1:0] syncQ;
  logic [LINES-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      prevQ    <= '0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], pinIn};
      prevQ    <= syncPipe[LAST];
    end
  end

  assign syncQ = syncPipe[LAST];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic riseSeen;
    logic fallSeen;
    logic edgeQual;

    assign riseSeen = syncQ[i] & ~prevQ[i];
    assign fallSeen = ~syncQ[i] & prevQ[i];

    always_comb begin
      if (bothEdges[i])        edgeQual = riseSeen | fallSeen;
      else if (polarityHigh[i]) edgeQual = riseSeen;
      else                      edgeQual = fallSeen;
    end

    assign strobes[i].isLevel     = senseLevel[i];
    assign strobes[i].levelActive = polarityHigh[i] ? syncQ[i] : ~syncQ[i];
    assign strobes[i].edgeHit     = ~senseLevel[i] & edgeQual;

    // An edge strobe only ever comes from a real change of the synchronised pin.
    p_edge_from_change_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].edgeHit |-> (syncQ[i] != prevQ[i]));

    // Both-edges mode reacts to a change in either direction.
    p_both_any_change_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!senseLevel[i] && bothEdges[i] && (syncQ[i] != prevQ[i])) |-> strobes[i].edgeHit);

    // Level sensing never produces an edge strobe.
    p_level_no_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
      senseLevel[i] |-> !strobes[i].edgeHit);
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strobes [LINES],
  input  logic [LINES-1:0]  clearPulse,
  input  logic [LINES-1:0]  lineEnable,
  output logic [LINES-1:0]  rawStatus,
  output logic [LINES-1:0]  maskedStatus,
  output logic              irqOut
);

  logic [LINES-1:0] rawQ;
  logic             irqQ;

  for (genvar i = 0; i < LINES; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    rawQ[i] <= 1'b0;
      else if (strobes[i].isLevel)  rawQ[i] <= strobes[i].levelActive;
      else if (strobes[i].edgeHit)  rawQ[i] <= 1'b1;
      else if (clearPulse[i])       rawQ[i] <= 1'b0;
    end

    // Latched edge status holds without a clear.
    p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[i].isLevel && rawQ[i] && !clearPulse[i]) |=> rawQ[i]);

    // A clear with no new edge drops latched edge status.
    p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[i].isLevel && !strobes[i].edgeHit && clearPulse[i]) |=> !rawQ[i]);

    // Level status follows the pin regardless of clear.
    p_level_track_r8: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].isLevel |=> (rawQ[i] == $past(strobes[i].levelActive)));

    // A new edge beats a coincident clear.
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].edgeHit && clearPulse[i]) |=> rawQ[i]);
  end

  assign maskedStatus = rawQ & lineEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |maskedStatus;
  end

  assign rawStatus = rawQ;
  assign irqOut    = irqQ;

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(maskedStatus != '0));

  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(maskedStatus == '0));

  p_masked_sub_raw_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~rawStatus) == '0);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  pinIn,
  input  logic [LINES-1:0]  senseLevel,
  input  logic [LINES-1:0]  polarityHigh,
  input  logic [LINES-1:0]  bothEdges,
  input  logic [LINES-1:0]  lineEnable,
  input  logic [LINES-1:0]  clearPulse,
  output logic [LINES-1:0]  rawStatus,
  output logic [LINES-1:0]  maskedStatus,
  output logic              irqOut
);

  lineStrobe_t strobes [LINES];

  gpio_irq_ctrl #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pinIn        (pinIn),
    .senseLevel   (senseLevel),
    .polarityHigh (polarityHigh),
    .bothEdges    (bothEdges),
    .strobes      (strobes)
  );

  gpio_irq_dp #(.LINES(LINES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .clearPulse   (clearPulse),
    .lineEnable   (lineEnable),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .irqOut       (irqOut)
  );

endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

  localparam int LINES = 8;
  localparam int NVEC  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LINES-1:0] pinIn = '0, senseLevel = '0, polarityHigh = '0, bothEdges = '0;
  logic [LINES-1:0] lineEnable = '0, clearPulse = '0;
  logic [LINES-1:0] rawStatus, maskedStatus;
  logic irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycleCnt = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.LINES(LINES), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .senseLevel(senseLevel),
    .polarityHigh(polarityHigh), .bothEdges(bothEdges), .lineEnable(lineEnable),
    .clearPulse(clearPulse), .rawStatus(rawStatus), .maskedStatus(maskedStatus),
    .irqOut(irqOut)
  );

  // {sense, polarity, both, pinsFirst, pinsSecond, expectedRaw}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'h0F},  // R4 rising
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h3C, 8'hC3},  // R5 falling
    {8'h00, 8'h55, 8'hF0, 8'hAA, 8'h66, 8'hCC},  // R4 R5 R6 mixed
    {8'hFF, 8'h0F, 8'h00, 8'h00, 8'h5A, 8'hAA},  // R2 R3 levels
    {8'hF0, 8'hFF, 8'h0F, 8'h0F, 8'h3C, 8'h33}   // R2 R6 mixed
  };
  string vecTag [NVEC] = '{"R4", "R5", "R6", "R3", "R6"};

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  task automatic check(string tag, logic [LINES-1:0] got, logic [LINES-1:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClear(logic [LINES-1:0] bits);
    clearPulse = bits;
    tick(1);
    clearPulse = '0;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 20000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycleCnt);
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 raw", rawStatus, '0);
    check("R1 masked", maskedStatus, '0);
    check("R1 irq", {7'd0, irqOut}, 8'd0);
    rstN = 1'b1;
    tick(2);

    // Table walk: R4 R5 R6 R3 R2, masked R9 and irq R10
    lineEnable = 8'hFF;
    for (int v = 0; v < NVEC; v++) begin
      senseLevel   = VEC[v][47:40];
      polarityHigh = VEC[v][39:32];
      bothEdges    = VEC[v][31:24];
      pinIn        = VEC[v][23:16];
      tick(5);
      pulseClear('1);
      tick(2);
      pinIn = VEC[v][15:8];
      tick(4);
      check(vecTag[v], rawStatus, VEC[v][7:0]);
      check("R9 table", maskedStatus, VEC[v][7:0]);
      check("R10 table", {7'd0, irqOut}, {7'd0, |VEC[v][7:0]});
    end

    // R2 latency and level tracking; R8 clear ignored on level
    lineEnable = '0; senseLevel = 8'hFF; polarityHigh = 8'hFF; bothEdges = '0;
    pinIn = '0;
    tick(5);
    pinIn = 8'h01;
    tick(2);
    check("R2 before third edge", rawStatus, 8'h00);
    tick(1);
    check("R2 on third edge", rawStatus, 8'h01);
    pulseClear(8'h01);
    tick(2);
    check("R8 clear ignored", rawStatus, 8'h01);
    pinIn = '0;
    tick(3);
    check("R2 drop", rawStatus, 8'h00);

    // R7 latch and clear
    senseLevel = '0; polarityHigh = 8'hFF;
    tick(4);
    pulseClear('1);
    pinIn = 8'h01;
    tick(3);
    check("R7 set", rawStatus, 8'h01);
    pinIn = 8'h00;
    tick(6);
    check("R7 held after pin drop", rawStatus, 8'h01);
    pulseClear(8'hFE);
    tick(2);
    check("R7 other bits", rawStatus, 8'h01);
    pulseClear(8'h01);
    tick(1);
    check("R7 cleared", rawStatus, 8'h00);

    // R9 / R10 enable gating and irq register
    pinIn = 8'h02;
    tick(3);
    check("R9 raw while disabled", rawStatus, 8'h02);
    check("R9 masked disabled", maskedStatus, 8'h00);
    check("R10 irq disabled", {7'd0, irqOut}, 8'd0);
    lineEnable = 8'h02;
    #1;
    check("R9 masked enabled", maskedStatus, 8'h02);
    check("R10 irq not yet", {7'd0, irqOut}, 8'd0);
    tick(1);
    check("R10 irq set", {7'd0, irqOut}, 8'd1);
    lineEnable = 8'h01;
    tick(1);
    check("R10 irq drop", {7'd0, irqOut}, 8'd0);

    // R11 edge coincident with clear
    bothEdges = 8'hFF; polarityHigh = 8'h00;
    pulseClear('1);
    tick(1);
    pinIn = 8'h06;
    tick(3);
    check("R6 both edges", rawStatus, 8'h04);
    pulseClear('1);
    tick(1);
    pinIn = 8'h02;
    tick(2);
    clearPulse = 8'h04;
    tick(1);
    clearPulse = '0;
    tick(2);
    check("R11 edge beats clear", rawStatus, 8'h04);
    pulseClear(8'h04);
    tick(1);
    check("R7 clear after R11", rawStatus, 8'h00);

    summary();
    $finish;
  end

endmodule